// File: doc/BRIEF.md
# Cascaded Timer Interrupt Decimator

This block pairs two down-counting timer channels so that a fast periodic interrupt can be divided into a slower one. The first channel is the primary timer. It counts enabled ticks of a shared count clock. Each time its count runs out, it emits a one-cycle pulse, inverts its toggle output and reloads. The second channel is the divider. It does not look at the count clock. It steps down once for each pulse from the primary timer and emits its own pulse once per programmed group of primary pulses. The result is a thinned copy of the primary interrupt stream.

Each channel has a pending data register that is written through a strobe and data port. A running counter reads that register only when it is started or when it reloads after expiry. A write during a count therefore changes the following period and leaves the current one as it is. Each channel also has a start input and a stop input. The primary timer has a mode bit that decides whether starting it also produces an immediate pulse and a toggle.

Top module: `timer_decimator`

## Requirements
- R1: While `rst` is high at a clock edge, both channels stop and all four outputs go to 0 after that edge.
- R2: A start loads the channel counter from its pending data value D. The primary timer then produces its first expiry pulse on the (D+1)-th enabled count clock after the start edge.
- R3: At a primary start, `start_irq_mode`=1 gives a `mst_irq` pulse in the cycle after the start edge and inverts `mst_tgl`. With `start_irq_mode`=0 neither happens. The divider start never produces a pulse.
- R4: When the running primary counter holds 0, the next enabled count clock gives a one-cycle `mst_irq` pulse, inverts `mst_tgl` and reloads the counter, all on the same edge. A steady value D gives one pulse every D+1 enabled count clocks.
- R5: The divider counter steps only on cycles where `mst_irq` is high. `cnt_en` has no direct effect on it. A divider pulse is always preceded, one cycle earlier, by a `mst_irq` pulse.
- R6: With divider data D, and both channels started together with mode 0, `slv_irq` pulses once for every D+1 `mst_irq` pulses. Each divider pulse appears one cycle after the primary pulse that completes the group.
- R7: A primary data write that lands during a count does not change the current period. It is used from the next primary reload onward.
- R8: A divider data write that lands during a count does not change the current group. It is used from the next divider reload onward.
- R9: A stop input freezes its channel and suppresses that channel's pulses until the next start. When start and stop arrive in the same cycle, the start wins.
- R10: Divider data 0 passes every primary pulse through, giving exactly one `slv_irq` per `mst_irq`.
- R11: `slv_tgl` inverts on every `slv_irq` pulse and holds its value at all other times. All outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-clock enable for the primary timer |
| start_irq_mode | input | 1 | 1: a primary start also pulses and toggles |
| mst_start | input | 1 | Primary channel start trigger |
| mst_stop | input | 1 | Primary channel stop |
| mst_wr | input | 1 | Write strobe for primary pending data |
| mst_wdata | input | CNT_W | Primary period data |
| slv_start | input | 1 | Divider channel start trigger |
| slv_stop | input | 1 | Divider channel stop |
| slv_wr | input | 1 | Write strobe for divider pending data |
| slv_wdata | input | CNT_W | Divider group-size data |
| mst_irq | output | 1 | Primary expiry pulse |
| mst_tgl | output | 1 | Primary toggle output |
| slv_irq | output | 1 | Thinned interrupt pulse |
| slv_tgl | output | 1 | Divider toggle output |

## Verification
The hardest behaviour to reach from the ports is a data write that lands while a count is already under way. Its effect only shows up one period later, and only if the reload point is located to the cycle. The stimulus waits for an observed pulse, writes new data in the cycles right after it, and then measures the next two intervals. For the primary timer the intervals are counted in enabled clocks. For the divider they are counted in primary pulses. The first interval must keep the old length and the second must take the new one. A start that coincides with a stop is exercised in a separate step.

// File: rtl/td_pkg.sv
package td_pkg;
  localparam int TD_NCH = 2;
  localparam int TD_MST = 0;
  localparam int TD_SLV = 1;

  typedef struct packed {
    logic start;
    logic stop;
    logic wr;
  } td_ctl_t;
endpackage

// File: rtl/td_datahold.sv
module td_datahold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  // pending value, consumed by the channel only at start or reload
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/td_channel.sv
module td_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         stop,
  input  logic         tick,
  input  logic         start_irq,
  input  logic [W-1:0] reload,
  output logic         irq,
  output logic         tgl
);
  logic         run;
  logic [W-1:0] cnt;
  logic         expire;

  assign expire = run && tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
      irq <= 1'b0;
      tgl <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (start) begin
        run <= 1'b1;
        cnt <= reload;
        if (start_irq) begin
          irq <= 1'b1;
          tgl <= ~tgl;
        end
      end else if (stop) begin
        run <= 1'b0;
      end else if (expire) begin
        cnt <= reload;
        irq <= 1'b1;
        tgl <= ~tgl;
      end else if (run && tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assert_start_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !start_irq) |=> (!irq && $stable(tgl)));
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (start && start_irq) |=> (irq && (tgl != $past(tgl))));
  assert_expire_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (expire && !start && !stop) |=> (irq && (cnt == $past(reload))));
  assert_stop_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> !irq);
  assert_toggle_follows_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (tgl != $past(tgl))));
endmodule

// File: rtl/timer_decimator.sv
module timer_decimator
  import td_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             start_irq_mode,
  input  logic             mst_start,
  input  logic             mst_stop,
  input  logic             mst_wr,
  input  logic [CNT_W-1:0] mst_wdata,
  input  logic             slv_start,
  input  logic             slv_stop,
  input  logic             slv_wr,
  input  logic [CNT_W-1:0] slv_wdata,
  output logic             mst_irq,
  output logic             mst_tgl,
  output logic             slv_irq,
  output logic             slv_tgl
);
  td_ctl_t          ctl_v   [TD_NCH];
  logic [CNT_W-1:0] wdata_v [TD_NCH];
  logic [CNT_W-1:0] hold_v  [TD_NCH];
  logic             irq_v   [TD_NCH];
  logic             tgl_v   [TD_NCH];

  assign ctl_v[TD_MST]   = '{start: mst_start, stop: mst_stop, wr: mst_wr};
  assign ctl_v[TD_SLV]   = '{start: slv_start, stop: slv_stop, wr: slv_wr};
  assign wdata_v[TD_MST] = mst_wdata;
  assign wdata_v[TD_SLV] = slv_wdata;

  for (genvar g = 0; g < TD_NCH; g++) begin : g_ch
    logic tick_g;
    logic mode_g;
    if (g == TD_MST) begin : g_src
      assign tick_g = cnt_en;
      assign mode_g = start_irq_mode;
    end else begin : g_src
      assign tick_g = irq_v[TD_MST];
      assign mode_g = 1'b0;
    end

    td_datahold #(.W(CNT_W)) i_hold (
      .clk   (clk),
      .rst   (rst),
      .wr    (ctl_v[g].wr),
      .wdata (wdata_v[g]),
      .q     (hold_v[g])
    );

    td_channel #(.W(CNT_W)) i_chan (
      .clk       (clk),
      .rst       (rst),
      .start     (ctl_v[g].start),
      .stop      (ctl_v[g].stop),
      .tick      (tick_g),
      .start_irq (mode_g),
      .reload    (hold_v[g]),
      .irq       (irq_v[g]),
      .tgl       (tgl_v[g])
    );
  end

  assign mst_irq = irq_v[TD_MST];
  assign mst_tgl = tgl_v[TD_MST];
  assign slv_irq = irq_v[TD_SLV];
  assign slv_tgl = tgl_v[TD_SLV];

  assert_slave_source_R5: assert property (@(posedge clk) disable iff (rst)
    slv_irq |-> $past(mst_irq));
endmodule

// File: tb/test_timer_decimator.sv
module test_timer_decimator;
  localparam int CLK_P = 10;
  localparam int W     = 16;

  logic         clk = 1'b0;
  logic         rst, cnt_en, start_irq_mode;
  logic         mst_start, mst_stop, mst_wr, slv_start, slv_stop, slv_wr;
  logic [W-1:0] mst_wdata, slv_wdata;
  logic         mst_irq, mst_tgl, slv_irq, slv_tgl;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  cmp_on = 0;
  bit  done   = 0;

  // behavioural reference state
  int  m_cnt, m_pend, s_cnt, s_pend;
  bit  m_run, s_run, m_irq, s_irq, m_tgl, s_tgl;

  always #(CLK_P/2) clk = ~clk;

  timer_decimator #(.CNT_W(W)) i_timer_decimator (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .start_irq_mode(start_irq_mode),
    .mst_start(mst_start), .mst_stop(mst_stop), .mst_wr(mst_wr), .mst_wdata(mst_wdata),
    .slv_start(slv_start), .slv_stop(slv_stop), .slv_wr(slv_wr), .slv_wdata(slv_wdata),
    .mst_irq(mst_irq), .mst_tgl(mst_tgl), .slv_irq(slv_irq), .slv_tgl(slv_tgl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, evaluated on each rising edge
  always @(posedge clk) begin
    bit s_next, m_next;
    if (rst) begin
      m_cnt = 0; m_pend = 0; s_cnt = 0; s_pend = 0;
      m_run = 0; s_run = 0; m_irq = 0; s_irq = 0; m_tgl = 0; s_tgl = 0;
    end else begin
      s_next = 0;
      if (slv_start) begin s_run = 1; s_cnt = s_pend; end
      else if (slv_stop) s_run = 0;
      else if (s_run && m_irq) begin
        if (s_cnt == 0) begin s_cnt = s_pend; s_next = 1; s_tgl = !s_tgl; end
        else s_cnt--;
      end
      if (slv_wr) s_pend = slv_wdata;
      m_next = 0;
      if (mst_start) begin
        m_run = 1; m_cnt = m_pend;
        if (start_irq_mode) begin m_next = 1; m_tgl = !m_tgl; end
      end else if (mst_stop) m_run = 0;
      else if (m_run && cnt_en) begin
        if (m_cnt == 0) begin m_cnt = m_pend; m_next = 1; m_tgl = !m_tgl; end
        else m_cnt--;
      end
      if (mst_wr) m_pend = mst_wdata;
      s_irq = s_next;
      m_irq = m_next;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(mst_irq == m_irq, "R4 mst_irq", mst_irq, m_irq);
      chk(mst_tgl == m_tgl, "R4 mst_tgl", mst_tgl, m_tgl);
      chk(slv_irq == s_irq, "R6 slv_irq", slv_irq, s_irq);
      chk(slv_tgl == s_tgl, "R11 slv_tgl", slv_tgl, s_tgl);
    end
  end

  task automatic gap_to_mst(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!mst_irq);
  endtask

  task automatic mst_to_slv(output int k);
    k = 0;
    do begin @(negedge clk); if (mst_irq) k++; end while (!slv_irq);
  endtask

  task automatic run_cycles(input int n, output int nm, output int ns);
    nm = 0; ns = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mst_irq) nm++;
      if (slv_irq) ns++;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int g, k, nm, ns, a, b;
    bit t0;
    rst = 1; cnt_en = 0; start_irq_mode = 0;
    mst_start = 0; mst_stop = 0; mst_wr = 0; mst_wdata = '0;
    slv_start = 0; slv_stop = 0; slv_wr = 0; slv_wdata = '0;
    repeat (3) @(negedge clk);
    cmp_on = 1;
    chk({mst_irq, mst_tgl, slv_irq, slv_tgl} == 4'b0, "R1 reset outputs",
        {mst_irq, mst_tgl, slv_irq, slv_tgl}, 0);
    rst = 0;

    // program: primary D=3, divider D=2, start both quietly
    mst_wr = 1; mst_wdata = 3; slv_wr = 1; slv_wdata = 2;
    @(negedge clk);
    mst_wr = 0; slv_wr = 0; mst_start = 1; slv_start = 1;
    @(negedge clk);
    mst_start = 0; slv_start = 0;
    chk(!mst_irq && !mst_tgl, "R3 quiet start", {mst_irq, mst_tgl}, 0);
    cnt_en = 1;
    gap_to_mst(g);
    chk(g == 4, "R2 first expiry count", g, 4);

    // R7: mid-period write of primary data
    mst_wr = 1; mst_wdata = 1;
    @(negedge clk);
    mst_wr = 0;
    gap_to_mst(g);
    chk(g + 1 == 4, "R7 current period kept", g + 1, 4);
    gap_to_mst(g);
    chk(g == 2, "R7 new period used", g, 2);

    // R6: ratio with primary D=3, divider D=2, restart together
    cnt_en = 0; mst_wr = 1; mst_wdata = 3;
    @(negedge clk);
    mst_wr = 0; mst_start = 1; slv_start = 1;
    @(negedge clk);
    mst_start = 0; slv_start = 0; cnt_en = 1;
    run_cycles(121, nm, ns);
    cnt_en = 0;
    run_cycles(4, a, b);
    nm += a; ns += b;
    chk(nm > 0 && ns == nm / 3, "R6 one per D+1", ns, nm / 3);

    // R10: divider D=0 passes every pulse
    slv_wr = 1; slv_wdata = 0;
    @(negedge clk);
    slv_wr = 0; slv_start = 1;
    @(negedge clk);
    slv_start = 0; cnt_en = 1;
    run_cycles(60, nm, ns);
    cnt_en = 0;
    run_cycles(3, a, b);
    nm += a; ns += b;
    chk(nm > 0 && ns == nm, "R10 pass-through", ns, nm);

    // R8: mid-group write of divider data
    cnt_en = 1;
    do @(negedge clk); while (!slv_irq);
    slv_wr = 1; slv_wdata = 2;
    @(negedge clk);
    slv_wr = 0;
    mst_to_slv(k);
    chk(k == 1, "R8 current group kept", k, 1);
    mst_to_slv(k);
    chk(k == 3, "R8 new group used", k, 3);

    // R9 and R5: stop the primary, divider must stay silent
    mst_stop = 1;
    @(negedge clk);
    mst_stop = 0;
    run_cycles(30, nm, ns);
    chk(nm == 0, "R9 stopped primary silent", nm, 0);
    chk(ns == 0, "R5 divider waits for pulses", ns, 0);

    // R3 mode 1 and R9 start beats stop
    t0 = mst_tgl;
    mst_start = 1; mst_stop = 1; start_irq_mode = 1;
    @(negedge clk);
    mst_start = 0; mst_stop = 0; start_irq_mode = 0;
    chk(mst_irq == 1, "R3 start pulse", mst_irq, 1);
    chk(mst_tgl != t0, "R9 start wins over stop", mst_tgl, !t0);

    run_cycles(50, nm, ns);
    chk(nm > 0, "R4 running after restart", nm, 1);
    finish_run();
  end
endmodule